// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Controller

This controller sits on the host side of an asynchronous pseudo-static memory and turns a read request into a sequence of pin-level accesses. A request carries a start word address, a word count and a configuration word. The first word of each access is read as a full random access. When page mode is enabled, later words in the same 16-word page are fetched by changing only the four low address bits, and each of these reads waits a shorter in-page latency.

Both latencies are counted in system-clock cycles and set by parameters. A request whose words run past the end of a page is split. Chip-enable is released for one cycle and a new full random access starts at the next page. Each word returns on a one-cycle strobe together with its address. A separate strobe marks the last word of the request.

While an access is in progress the controller holds the pins the way page mode needs them. The memory clock is low, address-valid is low and write-enable is high. The memory's wait output is not used.

Top module: `pgread_ctrl`

## Requirements
- R1: After reset, chip-enable and output-enable are high (inactive), `req_ready` is 1, and `rd_valid` and `rd_done` are 0.
- R2: The first word of a request appears on `rd_valid` exactly T_RAND clock cycles after the edge that accepts the request.
- R3: With page mode on, a following word in the same page appears exactly T_PAGE cycles after the previous word.
- R4: Page mode is taken from bit 7 of `cfg_word`, sampled when the request is accepted, and no other bit of `cfg_word` matters. When that bit is 0, every word is a separate full access: chip-enable goes high for one cycle, and the word appears T_RAND+1 cycles after the previous one.
- R5: When the next word's low four address bits are 0 (a page boundary was crossed), chip-enable goes high for one cycle and the word appears T_RAND+1 cycles after the previous one, whatever the page mode.
- R6: Whenever chip-enable is low, the memory clock is low, address-valid is low and write-enable is high.
- R7: While chip-enable stays low, address bits [ADDR_W-1:4] do not change.
- R8: `rd_done` pulses together with the last word of a request. Chip-enable is high from that cycle on, and `req_ready` returns to 1.
- R9: The `mem_wait` input has no effect on the returned words or their timing.
- R10: Each strobed word carries, on `rd_addr`, the address that was presented to the memory, and on `rd_data` the data the memory returned for that address. Word n of a request has address start+n.
- R11: While a request is in progress, `req_ready` is 0 and `req_valid` is ignored. No extra words are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Controller idle; a request is accepted |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Number of words (0 is read as 1) |
| cfg_word | input | CFG_W | Configuration word; bit 7 enables page mode |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, held high |
| mem_adv_n | output | 1 | Memory address-valid, low during accesses |
| mem_clk | output | 1 | Memory clock, held low |
| mem_wait | input | 1 | Memory wait output, ignored |
| mem_dq | input | DATA_W | Memory data pins |
| rd_valid | output | 1 | One-cycle strobe per word read |
| rd_addr | output | ADDR_W | Address of the strobed word |
| rd_data | output | DATA_W | Data of the strobed word |
| rd_done | output | 1 | Strobe with the last word of a request |

## Verification
Every result is due on a known cycle. The first word comes T_RAND edges after the accepting edge. Each in-page word comes T_PAGE edges after the previous one. Each word after a page crossing, or with page mode off, comes T_RAND+1 edges after the previous one. The driver counts edges from acceptance and stores the exact edge number of each expected word. The monitor compares that number with the edge counter at the falling edge after the strobe, so a word that arrives one cycle early or late is reported. The memory model in the bench returns valid data only after the address has been stable for the full or the in-page time, so a capture made before the latency has run out returns a marker value and fails.

// File: rtl/pgread_pkg.sv
// Package: shared types for the page-mode read controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pgread_pkg;

    // Controller phases: idle, full random access, in-page access, chip-enable gap
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_RAND = 2'd1,
        PG_PAGE = 2'd2,
        PG_GAP  = 2'd3
    } pg_state_e;

endpackage

// File: rtl/pgread_timer.sv
// Latency down-counter. A load sets the remaining cycles, the count then
// falls by one per clock and stops at zero; expired is high at zero.
// Assumes the loaded value fits CNT_W bits.
module pgread_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining latency cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgread_addr_seq.sv
// Address sequencer. Holds the current word address and the number of
// words still to read after it; flags the last word and the final word
// of a page. Assumes start and step never occur in the same cycle.
module pgread_addr_seq #(
    parameter int ADDR_W = 22,
    parameter int LEN_W  = 6,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              page_end
);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;

    // Load a new request or advance to the next word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (start) begin
            addr_q <= start_addr;
            rem_q  <= (start_len == '0) ? '0 : start_len - 1'b1;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr     = addr_q;
    assign last     = (rem_q == '0);
    assign page_end = &addr_q[PAGE_W-1:0];

endmodule

// File: rtl/pgread_ctrl.sv
// Page-mode asynchronous read controller (top).
// Accepts a read request, performs a full random access for the first
// word and for the first word of every new page, and in-page accesses
// for the following words when page mode is enabled. Pins are held in
// the page-mode state while chip-enable is low.
// Assumes T_RAND >= 1, T_PAGE >= 1 and that mem_dq is valid when the
// latency for the presented address has elapsed.
module pgread_ctrl
    import pgread_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 6,
    parameter int CFG_W     = 16,
    parameter int PAGE_W    = 4,
    parameter int PAGE_BIT  = 7,
    parameter int T_RAND    = 5,
    parameter int T_PAGE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic              mem_clk,
    input  logic              mem_wait,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    localparam int CNT_W = $clog2(T_RAND + 1);
    localparam logic [CNT_W-1:0] LOAD_RAND = CNT_W'(T_RAND - 1);
    localparam logic [CNT_W-1:0] LOAD_PAGE = CNT_W'(T_PAGE - 1);
    localparam logic [CFG_W-1:0] CFG_MASK  = CFG_W'(1) << PAGE_BIT;

    pg_state_e         state_q;
    logic              page_mode_q;
    logic              start;
    logic              step;
    logic              active;
    logic              go_page;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_last;
    logic              cur_page_end;
    logic              unused_wait;
    logic              unused_cfg;

    // The wait pin and the other configuration bits carry no meaning here
    assign unused_wait = mem_wait;
    assign unused_cfg  = ^(cfg_word & ~CFG_MASK);

    assign active  = (state_q == PG_RAND) || (state_q == PG_PAGE);
    assign start   = (state_q == PG_IDLE) && req_valid;
    assign step    = active && tmr_expired && !cur_last;
    assign go_page = page_mode_q && !cur_page_end;

    // Select when and with which latency the timer restarts
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = LOAD_RAND;
        if (start || (state_q == PG_GAP)) begin
            tmr_load = 1'b1;
            tmr_val  = LOAD_RAND;
        end else if (step && go_page) begin
            tmr_load = 1'b1;
            tmr_val  = LOAD_PAGE;
        end
    end

    pgread_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pgread_addr_seq #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_W     (PAGE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (req_addr),
        .start_len  (req_len),
        .step       (step),
        .addr       (cur_addr),
        .last       (cur_last),
        .page_end   (cur_page_end)
    );

    // Phase sequencing and word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PG_IDLE;
            page_mode_q <= 1'b0;
            rd_valid    <= 1'b0;
            rd_done     <= 1'b0;
            rd_addr     <= '0;
            rd_data     <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            unique case (state_q)
                PG_IDLE: begin
                    if (req_valid) begin
                        state_q     <= PG_RAND;
                        page_mode_q <= cfg_word[PAGE_BIT];
                    end
                end
                PG_RAND, PG_PAGE: begin
                    if (tmr_expired) begin
                        rd_valid <= 1'b1;
                        rd_addr  <= cur_addr;
                        rd_data  <= mem_dq;
                        if (cur_last) begin
                            rd_done <= 1'b1;
                            state_q <= PG_IDLE;
                        end else if (go_page) begin
                            state_q <= PG_PAGE;
                        end else begin
                            state_q <= PG_GAP;
                        end
                    end
                end
                PG_GAP: begin
                    state_q <= PG_RAND;
                end
                default: state_q <= PG_IDLE;
            endcase
        end
    end

    // Pin states: enabled only during accesses, page-mode levels held
    assign req_ready = (state_q == PG_IDLE);
    assign mem_addr  = cur_addr;
    assign mem_ce_n  = !active;
    assign mem_oe_n  = !active;
    assign mem_adv_n = !active;
    assign mem_we_n  = 1'b1;
    assign mem_clk   = 1'b0;

endmodule

// File: rtl/pgread_chk.sv
// Checker bound to pgread_ctrl: pin levels, page stability, release and
// busy behaviour. Assumes reset is held for at least one clock at start.
module pgread_chk #(
    parameter int ADDR_W = 22,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_adv_n,
    input logic              mem_clk,
    input logic              rd_valid,
    input logic              rd_done
);

    // R6: pin levels while the memory is selected
    assert_pin_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (!mem_clk && !mem_adv_n && mem_we_n));

    // R7: page bits frozen while chip-enable stays low
    assert_page_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

    // R8: chip-enable is released when the last word is reported
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (mem_ce_n && rd_valid));

    // R11: no new request is offered while the memory is selected
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R10: a word is only captured after outputs were enabled
    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

endmodule

bind pgread_ctrl pgread_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_clk   (mem_clk),
    .rd_valid  (rd_valid),
    .rd_done   (rd_done)
);

// File: tb/sim_pgread_ctrl.sv
// Scoreboard bench for pgread_ctrl: a driver pushes expected words with
// their due edge number; a monitor pops and compares as strobes appear.
module sim_pgread_ctrl;

    localparam int AW  = 22;
    localparam int DW  = 16;
    localparam int LW  = 6;
    localparam int CW  = 16;
    localparam int TR  = 5;
    localparam int TP  = 2;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            t;
        bit            last;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [CW-1:0] cfg_word = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_clk;
    logic          mem_wait = 1'b0;
    logic [DW-1:0] mem_dq;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_done;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   wait_noise = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pgread_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .LEN_W (LW), .CFG_W (CW),
        .T_RAND (TR), .T_PAGE (TP)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_len (req_len), .cfg_word (cfg_word),
        .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_adv_n (mem_adv_n), .mem_clk (mem_clk),
        .mem_wait (mem_wait), .mem_dq (mem_dq),
        .rd_valid (rd_valid), .rd_addr (rd_addr), .rd_data (rd_data),
        .rd_done (rd_done)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A5A;
    endfunction

    // Memory model: data is valid only after the required stable time
    int            age = 0;
    bit            page_ok = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          prev_ce_n = 1'b1;

    always @(negedge clk) begin
        if (wait_noise) mem_wait = $urandom_range(0, 1) == 1;
        else            mem_wait = 1'b0;
        if (mem_ce_n) begin
            age     = 0;
            page_ok = 1'b0;
        end else if (prev_ce_n || mem_addr != prev_addr) begin
            if (prev_ce_n || mem_addr[AW-1:4] != prev_addr[AW-1:4])
                page_ok = 1'b0;
            else if (age >= TR)
                page_ok = 1'b1;
            age = 1;
        end else begin
            age = age + 1;
        end
        prev_ce_n = mem_ce_n;
        prev_addr = mem_addr;
    end

    assign mem_dq = (!mem_ce_n && !mem_oe_n && (age >= TR || (page_ok && age >= TP)))
                    ? word_of(mem_addr) : 16'hDEAD;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: issue one request and push its expected words
    task automatic do_read(input logic [AW-1:0] addr, input int len, input bit pe,
                           input logic [CW-1:0] other, input bit busy_noise);
        int            e;
        int            t;
        logic [AW-1:0] a;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_word  = (other & ~16'h0080) | (pe ? 16'h0080 : 16'h0000);
        req_addr  = addr;
        req_len   = LW'(len);
        req_valid = 1'b1;
        e = cyc + 1;
        t = e;
        a = addr;
        for (int i = 0; i < len; i++) begin
            exp_t x;
            string tg;
            if (i == 0) begin
                t  = t + TR;
                tg = "R2";
            end else if (a[3:0] == 4'h0) begin
                t  = t + TR + 1;
                tg = "R5";
            end else if (pe) begin
                t  = t + TP;
                tg = "R3";
            end else begin
                t  = t + TR + 1;
                tg = "R4";
            end
            x.a = a; x.d = word_of(a); x.t = t; x.last = (i == len - 1); x.tag = tg;
            q.push_back(x);
            a = a + 1'b1;
        end
        @(negedge clk);
        cfg_word = ~cfg_word;
        if (busy_noise) begin
            req_addr = 22'h3ABC0;
            req_len  = LW'(7);
            check(!req_ready, "R11", "ready while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(mem_ce_n == 1'b1, "R8", "chip-enable after request", {31'd0, mem_ce_n}, 32'd1);
        check(req_ready == 1'b1, "R8", "ready after request", {31'd0, req_ready}, 32'd1);
    endtask

    // Monitor: pop and compare every strobed word
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_done && !rd_valid)
                check(1'b0, "R8", "done without word", 32'd1, 32'd0);
            if (rd_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11", "unexpected word", {10'd0, rd_addr}, 32'd0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check(rd_addr == x.a, "R10", "address", {10'd0, rd_addr}, {10'd0, x.a});
                    check(rd_data == x.d, "R10", "data", {16'd0, rd_data}, {16'd0, x.d});
                    check(cyc == x.t, x.tag, "due edge", cyc, x.t);
                    check(rd_done == x.last, "R8", "done strobe",
                          {31'd0, rd_done}, {31'd0, x.last});
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_ce_n == 1'b1, "R1", "ce_n in reset", {31'd0, mem_ce_n}, 32'd1);
        check(mem_oe_n == 1'b1, "R1", "oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
        check(req_ready == 1'b1, "R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        check(rd_valid == 1'b0 && rd_done == 1'b0, "R1", "strobes in reset",
              {30'd0, rd_valid, rd_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n == 1'b1 && req_ready == 1'b1, "R1", "idle after reset",
              {30'd0, mem_ce_n, req_ready}, 32'd3);

        do_read(22'h00100, 4, 1'b1, 16'h0000, 1'b0);   // R3 in-page words
        do_read(22'h00200, 3, 1'b0, 16'hFF7F, 1'b0);   // R4 page mode off, other bits set
        do_read(22'h0013D, 6, 1'b1, 16'h1234, 1'b0);   // R5 page crossing
        do_read(22'h00300, 16, 1'b1, 16'h0000, 1'b0);  // R3 full page
        do_read(22'h00555, 1, 1'b1, 16'h0000, 1'b0);   // R2 single word
        wait_noise = 1'b1;                              // R9 wait pin toggling
        do_read(22'h002A7, 12, 1'b1, 16'h0000, 1'b0);
        do_read(22'h00410, 3, 1'b0, 16'h0000, 1'b0);
        wait_noise = 1'b0;
        do_read(22'h003F5, 40, 1'b1, 16'h0F0F, 1'b0);  // R5 multiple pages
        do_read(22'h00620, 5, 1'b1, 16'h0000, 1'b1);   // R11 requests while busy
        do_read(22'h00700, 1, 1'b0, 16'h0000, 1'b1);   // R11 single word
        repeat (20) @(negedge clk);
        check(q.size() == 0 && req_ready, "R11", "no leftover words",
              q.size(), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule